// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block runs external bus cycles for a processor whose 20-bit address and 16-bit data share one set of lines. A requester presents a segment value, an offset, a direction, a memory-or-I/O choice, a byte-or-word size and a segment class. The block forms the physical address and steps through four bus phases. Phase one carries the address and an address-latch pulse. The later phases carry data and status. When the target holds the ready input low, the block adds wait states. At the end it raises a one-cycle completion flag and presents any data it has read.

Byte lanes are picked with the bus-high-enable output together with address bit 0. A word access at an odd address cannot be served in one transfer, so the block splits it into two byte transfers. When reset ends, the block reads one word at the restart address before it accepts any request.

Top module: `mbus_cycle_seq`

## Requirements
- R1: The physical address is the 16-bit segment shifted left by 4 plus the zero-extended 16-bit offset, truncated to 20 bits, so a sum past FFFFFh wraps.
- R2: In the first cycle after reset, busy is high and every strobe is inactive. The block then reads one memory word at FFFF0h with segment class 2'b10 before it accepts a request.
- R3: In T1, ale is high for exactly one cycle. ad_out carries address bits 15:0 with ad_oe high. For a memory cycle, a_hi carries address bits 19:16.
- R4: For a memory cycle, a_hi carries {2'b00, class} in T2, T3, every Tw and T4. The class codes are 00 alternate, 01 stack, 10 code and 11 data. For an I/O cycle, a_hi is 0 for the whole cycle.
- R5: In T1, the pair {bhe_n, A0} is 00 for a word at an even address, 01 for the upper byte at an odd address and 10 for the lower byte at an even address.
- R6: In a write cycle, dt_r is high. ad_oe is high from T2 to T4 and ad_out carries the data. A byte at an even address goes on bits 7:0, a byte at an odd address goes on bits 15:8, and the unused lane is 0. wr_n is low from T2 through the last T3/Tw, and rd_n stays high.
- R7: In a read cycle, dt_r is low and ad_oe is low from T2 to T4. rd_n is low from T2 through the last T3/Tw. ad_in is captured at the end of the last T3/Tw. Bits 15:8 are taken at an odd address and bits 7:0 at an even one. A byte read returns {8'h00, byte}.
- R8: ready is sampled at the end of T3 and at the end of each Tw. While it is low, Tw states are added between T3 and T4, with the strobes and status held.
- R9: A word at odd address A runs as two byte cycles. The first is at A and carries data bits 7:0. The second is at A+1 and carries data bits 15:8.
- R10: done is high only during the final T4 of a request. busy is high from acceptance to that T4. A request presented while busy, including during the done cycle, is ignored.
- R11: m_io is high for memory cycles and low for I/O cycles. den_n is low from T2 to T4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present, taken when not busy |
| req_seg | input | 16 | Segment value |
| req_off | input | 16 | Offset |
| req_write | input | 1 | 1 write, 0 read |
| req_mem | input | 1 | 1 memory, 0 I/O |
| req_word | input | 1 | 1 word, 0 byte |
| req_kind | input | 2 | Segment class shown as status |
| req_wdata | input | 16 | Write data (byte in bits 7:0) |
| busy | output | 1 | A request or the restart read is in progress |
| done | output | 1 | Completion pulse |
| rd_data | output | 16 | Read result |
| ad_in | input | 16 | Shared lines, input side |
| ad_out | output | 16 | Shared lines, output side |
| ad_oe | output | 1 | Output enable for the shared lines |
| a_hi | output | 4 | Upper address / status lines |
| ale | output | 1 | Address latch pulse |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| m_io | output | 1 | 1 memory, 0 I/O |
| dt_r | output | 1 | 1 transmit, 0 receive |
| den_n | output | 1 | Transceiver enable, active low |
| bhe_n | output | 1 | Bus high enable, active low |
| ready | input | 1 | Target ready, low inserts waits |

## Verification
Two pairs of events can land on the same cycle. In the final T4, done coincides with a request that is already waiting. On the edge that ends the last wait state, the read capture coincides with the exit from waiting. The first pair is provoked by holding req_valid high through a whole write cycle, including the done cycle. It is judged correct if no T1 follows and busy is low one cycle later. The second pair is provoked by keeping a decoy pattern on ad_in during every wait-stalled T3/Tw and placing the real data only in the cycle where ready rises. Each lane's byte is packed next to filler, so any capture taken a cycle early, or from the wrong half of the bus, shows up in rd_data.

// File: rtl/mbus_pkg.sv
// Shared types for the bus cycle sequencer.
package mbus_pkg;
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_T2   = 3'd2,
        PH_T3   = 3'd3,
        PH_TW   = 3'd4,
        PH_T4   = 3'd5
    } phase_t;
endpackage

// File: rtl/mbus_addr_gen.sv
// Physical address former: segment shifted into the upper bits plus offset.
// Assumes ADDR_W > OFF_W; the sum wraps modulo 2**ADDR_W.
module mbus_addr_gen #(
    parameter int ADDR_W = 20,
    parameter int OFF_W  = 16
) (
    input  logic [OFF_W-1:0]  seg,
    input  logic [OFF_W-1:0]  off,
    output logic [ADDR_W-1:0] phys
);
    localparam int SHIFT = ADDR_W - OFF_W;

    // Shifted segment plus zero-extended offset.
    always_comb begin
        phys = {seg, {SHIFT{1'b0}}} + {{SHIFT{1'b0}}, off};
    end
endmodule

// File: rtl/mbus_lane_sel.sv
// Byte-lane selector: decides whether a transfer is a full word,
// picks the byte to send and places it on the lane given by address bit 0.
// Assumes DATA_W is even; split transfers send low byte first, high byte second.
module mbus_lane_sel #(
    parameter int DATA_W = 16
) (
    input  logic              a0,
    input  logic              word_req,
    input  logic              split,
    input  logic              half,
    input  logic [DATA_W-1:0] wdata,
    output logic              eff_word,
    output logic              bhe_n,
    output logic [DATA_W-1:0] lane_wdata
);
    localparam int BYTE_W = DATA_W / 2;

    logic [BYTE_W-1:0] sel_byte;

    // Choose the byte and its lane for the current transfer.
    always_comb begin
        eff_word = word_req & ~split;
        sel_byte = (split && half) ? wdata[DATA_W-1:BYTE_W] : wdata[BYTE_W-1:0];
        if (eff_word)
            lane_wdata = wdata;
        else if (a0)
            lane_wdata = {sel_byte, {BYTE_W{1'b0}}};
        else
            lane_wdata = {{BYTE_W{1'b0}}, sel_byte};
        bhe_n = ~(eff_word | a0);
    end
endmodule

// File: rtl/mbus_phase_fsm.sv
// Bus phase sequencer: IDLE -> T1 -> T2 -> T3 -> (Tw)* -> T4, repeated once
// more for the second half of a split access. Assumes split is stable while busy.
module mbus_phase_fsm
    import mbus_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   go,
    input  logic   ready,
    input  logic   split,
    output phase_t phase,
    output logic   half,
    output logic   capture,
    output logic   done
);
    // Phase and half-counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            half  <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: if (go) begin
                    phase <= PH_T1;
                    half  <= 1'b0;
                end
                PH_T1: phase <= PH_T2;
                PH_T2: phase <= PH_T3;
                PH_T3, PH_TW: phase <= ready ? PH_T4 : PH_TW;
                PH_T4: if (split && !half) begin
                    phase <= PH_T1;
                    half  <= 1'b1;
                end else begin
                    phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Capture strobe and completion flag.
    always_comb begin
        capture = ((phase == PH_T3) || (phase == PH_TW)) && ready;
        done    = (phase == PH_T4) && (!split || half);
    end

    // R8: a low ready at the end of T3/Tw holds the bus in Tw
    p_wait_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (((phase == PH_T3) || (phase == PH_TW)) && !ready) |=> (phase == PH_TW));

    // R8: a high ready at the end of T3/Tw moves on to T4
    p_wait_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (((phase == PH_T3) || (phase == PH_TW)) && ready) |=> (phase == PH_T4));
endmodule

// File: rtl/mbus_cycle_seq.sv
// Multiplexed address/data bus cycle sequencer (top).
// Latches one request, forms the physical address, drives the bus phases with
// ready-driven waits, splits odd-address words into two byte cycles and
// captures read data. After reset it runs one word read at BOOT_ADDR.
// Assumes the shared lines are split into in/out/enable by the pad ring.
module mbus_cycle_seq
    import mbus_pkg::*;
#(
    parameter int                 ADDR_W    = 20,
    parameter int                 DATA_W    = 16,
    parameter int                 KIND_W    = 2,
    parameter logic [ADDR_W-1:0]  BOOT_ADDR = 20'hFFFF0,
    parameter logic [KIND_W-1:0]  BOOT_KIND = 2'b10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [DATA_W-1:0] req_seg,
    input  logic [DATA_W-1:0] req_off,
    input  logic              req_write,
    input  logic              req_mem,
    input  logic              req_word,
    input  logic [KIND_W-1:0] req_kind,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [ADDR_W-DATA_W-1:0] a_hi,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              m_io,
    output logic              dt_r,
    output logic              den_n,
    output logic              bhe_n,
    input  logic              ready
);
    localparam int HI_W   = ADDR_W - DATA_W;
    localparam int BYTE_W = DATA_W / 2;

    phase_t              phase;
    logic                half, capture, go, idle, split, eff_word, lane_bhe_n;
    logic                boot_pend;
    logic [ADDR_W-1:0]   req_phys, cur_addr, bus_addr;
    logic                cur_write, cur_mem, cur_word;
    logic [KIND_W-1:0]   cur_kind;
    logic [DATA_W-1:0]   cur_wdata, lane_wdata, rd_q;
    logic [BYTE_W-1:0]   byte_in;
    logic [HI_W-1:0]     status;

    mbus_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(DATA_W)) u_addr (
        .seg  (req_seg),
        .off  (req_off),
        .phys (req_phys)
    );

    mbus_phase_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go),
        .ready   (ready),
        .split   (split),
        .phase   (phase),
        .half    (half),
        .capture (capture),
        .done    (done)
    );

    mbus_lane_sel #(.DATA_W(DATA_W)) u_lane (
        .a0         (bus_addr[0]),
        .word_req   (cur_word),
        .split      (split),
        .half       (half),
        .wdata      (cur_wdata),
        .eff_word   (eff_word),
        .bhe_n      (lane_bhe_n),
        .lane_wdata (lane_wdata)
    );

    // Request bookkeeping derived from the phase and the latched request.
    always_comb begin
        idle     = (phase == PH_IDLE);
        go       = idle & (boot_pend | req_valid);
        busy     = ~idle | boot_pend;
        split    = cur_word & cur_addr[0];
        bus_addr = cur_addr + ADDR_W'(half);
        status   = {{(HI_W-KIND_W){1'b0}}, cur_kind};
        byte_in  = bus_addr[0] ? ad_in[DATA_W-1:BYTE_W] : ad_in[BYTE_W-1:0];
    end

    // Latch the restart read or a new request while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boot_pend <= 1'b1;
            cur_addr  <= '0;
            cur_write <= 1'b0;
            cur_mem   <= 1'b0;
            cur_word  <= 1'b0;
            cur_kind  <= '0;
            cur_wdata <= '0;
        end else if (idle) begin
            if (boot_pend) begin
                boot_pend <= 1'b0;
                cur_addr  <= BOOT_ADDR;
                cur_write <= 1'b0;
                cur_mem   <= 1'b1;
                cur_word  <= 1'b1;
                cur_kind  <= BOOT_KIND;
                cur_wdata <= '0;
            end else if (req_valid) begin
                cur_addr  <= req_phys;
                cur_write <= req_write;
                cur_mem   <= req_mem;
                cur_word  <= req_word;
                cur_kind  <= req_kind;
                cur_wdata <= req_wdata;
            end
        end
    end

    // Capture read data from the selected lane at the last T3/Tw.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (capture && !cur_write) begin
            if (eff_word)
                rd_q <= ad_in;
            else if (split && half)
                rd_q[DATA_W-1:BYTE_W] <= byte_in;
            else if (split)
                rd_q[BYTE_W-1:0] <= byte_in;
            else
                rd_q <= {{BYTE_W{1'b0}}, byte_in};
        end
    end

    assign rd_data = rd_q;

    // Bus pin decode per phase.
    always_comb begin
        ale    = 1'b0;
        ad_out = '0;
        ad_oe  = 1'b0;
        a_hi   = '0;
        rd_n   = 1'b1;
        wr_n   = 1'b1;
        m_io   = 1'b0;
        dt_r   = 1'b1;
        den_n  = 1'b1;
        bhe_n  = 1'b1;
        if (!idle) begin
            m_io = cur_mem;
            dt_r = cur_write;
        end
        case (phase)
            PH_T1: begin
                ale    = 1'b1;
                ad_out = bus_addr[DATA_W-1:0];
                ad_oe  = 1'b1;
                a_hi   = cur_mem ? bus_addr[ADDR_W-1:DATA_W] : '0;
                bhe_n  = lane_bhe_n;
            end
            PH_T2, PH_T3, PH_TW, PH_T4: begin
                a_hi  = cur_mem ? status : '0;
                den_n = 1'b0;
                if (cur_write) begin
                    ad_oe  = 1'b1;
                    ad_out = lane_wdata;
                end
                if (phase != PH_T4) begin
                    if (cur_write) wr_n = 1'b0;
                    else           rd_n = 1'b0;
                end
            end
            default: ;
        endcase
    end

    // R3: the address latch pulse lasts a single cycle
    p_ale_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    // R6: the two strobes are never low together
    p_rw_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R7: the read strobe opens only right after the address phase
    p_rd_after_ale_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_n) |-> $past(ale));

    // R10: completion is a single-cycle pulse
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: upper lines stay low whenever the cycle is not a memory cycle
    p_io_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !m_io |-> (a_hi == '0));
endmodule

// File: tb/mbus_cycle_seq_tb.sv
// Directed bench for the bus cycle sequencer; acts as the bus target.
module mbus_cycle_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_seg = '0, req_off = '0, req_wdata = '0;
    logic        req_write = 1'b0, req_mem = 1'b0, req_word = 1'b0;
    logic [1:0]  req_kind = '0;
    logic        busy, done, ad_oe, ale, rd_n, wr_n, m_io, dt_r, den_n, bhe_n;
    logic [15:0] rd_data, ad_out;
    logic [15:0] ad_in = '0;
    logic [3:0]  a_hi;
    logic        ready = 1'b1;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    mbus_cycle_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_seg(req_seg),
        .req_off(req_off), .req_write(req_write), .req_mem(req_mem),
        .req_word(req_word), .req_kind(req_kind), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rd_data(rd_data), .ad_in(ad_in),
        .ad_out(ad_out), .ad_oe(ad_oe), .a_hi(a_hi), .ale(ale), .rd_n(rd_n),
        .wr_n(wr_n), .m_io(m_io), .dt_r(dt_r), .den_n(den_n), .bhe_n(bhe_n),
        .ready(ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG) begin
            fails = fails + 1;
            $display("FAIL R10 watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [19:0] phys_of(input logic [15:0] s, input logic [15:0] o);
        return {s, 4'h0} + {4'h0, o};   // R1
    endfunction

    task automatic issue(input logic [15:0] s, input logic [15:0] o, input logic w,
                         input logic m, input logic wd, input logic [1:0] k,
                         input logic [15:0] dat);
        req_seg = s; req_off = o; req_write = w; req_mem = m;
        req_word = wd; req_kind = k; req_wdata = dat; req_valid = 1'b1;
    endtask

    // Walk one request through its bus cycles, checking every phase.
    task automatic run_bus(input logic [19:0] a, input logic w, input logic m,
                           input logic wd, input logic [1:0] k, input logic [15:0] dat,
                           input int nw0, input int nw1, input bit spam);
        logic split, ew, odd, expbhe;
        logic [19:0] ba;
        logic [7:0]  bsel;
        logic [15:0] lane, rlane, exp_rd;
        int nh, nw;
        split  = wd & a[0];
        nh     = split ? 2 : 1;
        exp_rd = (wd) ? dat : {8'h00, dat[7:0]};
        for (int h = 0; h < nh; h++) begin
            ba     = 20'(a + 20'(h));
            ew     = wd & ~split;
            odd    = ba[0];
            bsel   = (split && h == 1) ? dat[15:8] : dat[7:0];
            lane   = ew ? dat : (odd ? {bsel, 8'h00} : {8'h00, bsel});
            rlane  = ew ? dat : (odd ? {bsel, 8'hC3} : {8'hC3, bsel});
            expbhe = ~(ew | odd);
            nw     = (h == 0) ? nw0 : nw1;
            // T1
            @(negedge clk);
            if (!spam) req_valid = 1'b0;
            chk("R3 ale in T1", ale, 1);
            chk("R3 low address in T1", ad_out, ba[15:0]);
            chk("R3 ad_oe in T1", ad_oe, 1);
            chk("R3/R4 upper lines in T1", a_hi, m ? ba[19:16] : 4'h0);
            chk("R5 bhe_n in T1", bhe_n, expbhe);
            chk("R9 A0 of transfer", ad_out[0], odd);
            chk("R11 m_io", m_io, m);
            chk("R6/R7 dt_r", dt_r, w);
            // T2
            @(negedge clk);
            chk("R3 ale ends after T1", ale, 0);
            chk("R4 status in T2", a_hi, m ? {2'b00, k} : 4'h0);
            chk("R6 wr_n in T2", wr_n, !w);
            chk("R7 rd_n in T2", rd_n, w);
            chk("R11 den_n in T2", den_n, 0);
            chk("R6/R7 ad_oe in T2", ad_oe, w);
            if (w) chk("R6/R9 write lane in T2", ad_out, lane);
            // T3
            @(negedge clk);
            chk("R8 strobe in T3", {rd_n, wr_n}, w ? 2'b10 : 2'b01);
            ready = (nw == 0);
            ad_in = (nw == 0) ? rlane : 16'h5A5A;
            for (int i = 0; i < nw; i++) begin
                @(negedge clk);
                chk("R8 strobe held in Tw", {rd_n, wr_n}, w ? 2'b10 : 2'b01);
                chk("R8 status held in Tw", a_hi, m ? {2'b00, k} : 4'h0);
                chk("R8 no done during Tw", done, 0);
                ready = (i == nw - 1);
                ad_in = (i == nw - 1) ? rlane : 16'h5A5A;
            end
            // T4
            @(negedge clk);
            ready = 1'b1;
            ad_in = 16'h0000;
            chk("R6/R7 strobes released in T4", {rd_n, wr_n}, 2'b11);
            chk("R11 den_n in T4", den_n, 0);
            chk("R4 status in T4", a_hi, m ? {2'b00, k} : 4'h0);
            chk("R10 done only in final T4", done, (h == nh - 1));
            if (w) chk("R6 write data held in T4", ad_out, lane);
            if (!w && h == nh - 1) chk("R7/R9 read data", rd_data, exp_rd);
        end
        if (spam) req_valid = 1'b0;
        @(negedge clk);
        chk("R10 idle after done", busy, 0);
        chk("R10 no new address phase", ale, 0);
    endtask

    task automatic t_reset_and_boot();
        @(negedge clk);
        @(negedge clk);
        chk("R2 busy in reset", busy, 1);
        chk("R2 strobes idle in reset", {ale, rd_n, wr_n, den_n, done}, 5'b01110);
        rst_n = 1'b1;
        run_bus(20'hFFFF0, 1'b0, 1'b1, 1'b1, 2'b10, 16'hEA5B, 0, 0, 1'b0); // R2
    endtask

    task automatic t_word_write();
        issue(16'h1234, 16'h0010, 1'b1, 1'b1, 1'b1, 2'b11, 16'hBEEF);
        chk("R1 address of 1234:0010", phys_of(16'h1234, 16'h0010), 20'h12350);
        run_bus(phys_of(16'h1234, 16'h0010), 1'b1, 1'b1, 1'b1, 2'b11, 16'hBEEF, 0, 0, 1'b0);
    endtask

    task automatic t_word_read_waits();
        issue(16'h2000, 16'h0104, 1'b0, 1'b1, 1'b1, 2'b01, 16'h1357);
        run_bus(phys_of(16'h2000, 16'h0104), 1'b0, 1'b1, 1'b1, 2'b01, 16'h1357, 3, 0, 1'b0); // R8
    endtask

    task automatic t_io_byte_read_odd();
        issue(16'h0000, 16'h0061, 1'b0, 1'b0, 1'b0, 2'b00, 16'h007E);
        run_bus(phys_of(16'h0000, 16'h0061), 1'b0, 1'b0, 1'b0, 2'b00, 16'h007E, 1, 0, 1'b0); // R4 R5
    endtask

    task automatic t_byte_write_even();
        issue(16'h0400, 16'h0022, 1'b1, 1'b1, 1'b0, 2'b11, 16'h77A9);
        run_bus(phys_of(16'h0400, 16'h0022), 1'b1, 1'b1, 1'b0, 2'b11, 16'h77A9, 0, 0, 1'b0); // R5 R6
    endtask

    task automatic t_split_read();
        issue(16'h3000, 16'h00FF, 1'b0, 1'b1, 1'b1, 2'b11, 16'hC0DE);
        run_bus(phys_of(16'h3000, 16'h00FF), 1'b0, 1'b1, 1'b1, 2'b11, 16'hC0DE, 0, 2, 1'b0); // R9
    endtask

    task automatic t_split_write();
        issue(16'h5000, 16'h0001, 1'b1, 1'b1, 1'b1, 2'b00, 16'h8421);
        run_bus(phys_of(16'h5000, 16'h0001), 1'b1, 1'b1, 1'b1, 2'b00, 16'h8421, 1, 1, 1'b0); // R9
    endtask

    task automatic t_wrap();
        issue(16'hFFFF, 16'h0024, 1'b0, 1'b1, 1'b1, 2'b11, 16'h600D);
        chk("R1 wrapped address", phys_of(16'hFFFF, 16'h0024), 20'h00014);
        run_bus(20'h00014, 1'b0, 1'b1, 1'b1, 2'b11, 16'h600D, 0, 0, 1'b0);
    endtask

    task automatic t_busy_ignore();
        issue(16'h0000, 16'h0300, 1'b1, 1'b0, 1'b1, 2'b01, 16'h1F2E);
        run_bus(20'h00300, 1'b1, 1'b0, 1'b1, 2'b01, 16'h1F2E, 1, 0, 1'b1); // R10
    endtask

    initial begin
        t_reset_and_boot();
        t_word_write();
        t_word_read_waits();
        t_io_byte_read_odd();
        t_byte_write_even();
        t_split_read();
        t_split_write();
        t_wrap();
        t_busy_ignore();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule